// File: doc/BRIEF.md
# Single-MAC Two-Layer Network Evaluator

This block computes a small fully connected network (one hidden layer followed by one output layer) using exactly one signed multiplier and one accumulator, shared by every neuron of both layers. A controller made of three nested counters walks the layer, the neuron inside that layer and the input inside that neuron. For each step it steers one input operand, one weight and one bias into the shared arithmetic. Every neuron accumulates its products, adds its bias, and then resolves in a final step. Hidden neurons are shifted and clamped into a non-negative fixed-point value. Output neurons keep their raw signed sum.

Hidden results go into one of two alternating register banks. The primary input vector is captured into the other bank, so a layer never overwrites the operands it is still reading. A run is requested through a valid/ready pair, and the vector on `x_vec` is captured on the accepting edge. There is no back-pressure on the result side. When the last output neuron is written, `done` pulses for one cycle. The raw scores and the index of the largest score then stay on the outputs until the next run is accepted. Weights and biases are supplied as flat arrays on ports and must stay constant while a run is in progress.

Top module: `mac_net_seq`

## Requirements
- R1: After reset, `done` is 0, `start_ready` is 1, every entry of `scores` is 0 and `best_idx` is 0.
- R2: `start_ready` is high only while no run is in progress. A `start_valid` that arrives while a run is in progress is ignored: the run in progress is not restarted, and a `x_vec` presented then has no effect on its results.
- R3: `done` rises exactly L = (IN_CNT+2)·HID_CNT + (HID_CNT+2)·OUT_CNT clock edges after the edge on which `start_valid && start_ready` was sampled high.
- R4: `done` is high for exactly one cycle per run, and `start_ready` is high in that same cycle.
- R5: Hidden neuron j (0 ≤ j < HID_CNT) takes s = b_mem[j] + Σi w_mem[j·IN_CNT+i]·x[i] with signed DW-bit operands. Its value is (s >>> SHIFT), clamped to the range 0 … 2^(DW-1)−1.
- R6: Output score k (0 ≤ k < OUT_CNT) is b_mem[HID_CNT+k] + Σj w_mem[IN_CNT·HID_CNT + k·HID_CNT + j]·h[j]. It is presented as a signed AW-bit value with no shift and no clamp, so it may be negative.
- R7: `best_idx` is the index of the largest signed score. When several scores are equal and largest, the lowest index wins.
- R8: While no run is in progress and none is being accepted, `scores` and `best_idx` hold their values.
- R9: Back-to-back runs are independent: a run accepted in the same cycle as the previous `done` gives results that depend only on its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request to evaluate the vector on `x_vec` |
| start_ready | output | 1 | High when a request can be accepted (block idle) |
| x_vec | input | IN_CNT×DW | Primary inputs, signed, captured on acceptance |
| w_mem | input | (IN_CNT·HID_CNT+HID_CNT·OUT_CNT)×DW | Signed weights, hidden rows first, then output rows |
| b_mem | input | (HID_CNT+OUT_CNT)×BW | Signed biases, hidden neurons first |
| scores | output | OUT_CNT×AW | Raw signed output-layer sums |
| best_idx | output | max(1,clog2(OUT_CNT)) | Index of the largest score |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong count in any of the three counters changes the number of cycles between acceptance and `done`. The latency check exposes it on the first run. An accumulator that is not cleared between neurons, a bias added twice, or a hidden value written into the bank being read all corrupt the scores. That corruption is visible at the next `done`, within one run of L cycles. A clamp or sign fault appears only with saturating or negative data, so those patterns are driven explicitly. A leak of the idle hold or of the busy-time request shows at the ports as changed scores or a restarted latency.

// File: rtl/nnseq_pkg.sv
package nnseq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_MAC, PH_BIAS, PH_ACT} phase_e;

  localparam int NLAYER = 2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nnseq_ctrl.sv
module nnseq_ctrl import nnseq_pkg::*; #(
  parameter int IN_CNT  = 4,
  parameter int HID_CNT = 3,
  parameter int OUT_CNT = 2,
  parameter int CW      = 4,
  parameter int NWD     = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_valid,
  output logic           start_ready,
  output logic           busy,
  output logic           lay,
  output logic [NWD-1:0] neu,
  output logic [CW-1:0]  inp,
  output phase_e         phase,
  output logic           done
);
  localparam logic LAST_LAY = 1'(NLAYER - 1);

  logic [CW-1:0]  cur_in;
  logic [NWD-1:0] cur_last;

  assign start_ready = !busy;

  always_comb begin
    cur_in   = lay ? CW'(HID_CNT) : CW'(IN_CNT);
    cur_last = lay ? NWD'(OUT_CNT - 1) : NWD'(HID_CNT - 1);
  end

  always_comb begin
    if (!busy)              phase = PH_IDLE;
    else if (inp < cur_in)  phase = PH_MAC;
    else if (inp == cur_in) phase = PH_BIAS;
    else                    phase = PH_ACT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lay  <= 1'b0;
      neu  <= '0;
      inp  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_valid) begin
          busy <= 1'b1;
          lay  <= 1'b0;
          neu  <= '0;
          inp  <= '0;
        end
      end else if (phase == PH_ACT) begin
        inp <= '0;
        if (neu == cur_last) begin
          neu <= '0;
          if (lay == LAST_LAY) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            lay <= lay + 1'b1;
          end
        end else begin
          neu <= neu + 1'b1;
        end
      end else begin
        inp <= inp + 1'b1;
      end
    end
  end

  // R2: a run only begins from a request
  assert_accept_from_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid));

  // R4: done never lasts two cycles
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: done only when the sequencer has stopped
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: counters stay inside the schedule of the current layer
  assert_counter_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (inp <= cur_in + 1'b1) && (neu <= cur_last));
endmodule

// File: rtl/nnseq_mac.sv
module nnseq_mac import nnseq_pkg::*; #(
  parameter int DW    = 8,
  parameter int BW    = 16,
  parameter int AW    = 20,
  parameter int SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  phase_e               phase,
  input  logic                 first,
  input  logic [DW-1:0]        x,
  input  logic [DW-1:0]        w,
  input  logic [BW-1:0]        bias,
  output logic signed [AW-1:0] acc,
  output logic [DW-1:0]        act
);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (DW - 1)) - 1);

  logic signed [2*DW-1:0] prod;
  logic signed [BW-1:0]   bias_s;
  logic signed [AW-1:0]   sh;

  assign prod   = $signed(x) * $signed(w);
  assign bias_s = $signed(bias);
  assign sh     = acc >>> SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else begin
      case (phase)
        PH_MAC:  acc <= (first ? '0 : acc) + AW'(prod);
        PH_BIAS: acc <= acc + AW'(bias_s);
        default: acc <= acc;
      endcase
    end
  end

  always_comb begin
    if (sh < 0)         act = '0;
    else if (sh > MAXV) act = DW'(MAXV);
    else                act = sh[DW-1:0];
  end

  // R5: the activation never produces a negative hidden value
  assert_act_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACT) |-> !act[DW-1]);

  // R3: the bias step is always followed by the resolve step
  assert_bias_then_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BIAS) |=> (phase == PH_ACT));
endmodule

// File: rtl/nnseq_argmax.sv
module nnseq_argmax #(
  parameter int OUT_CNT = 2,
  parameter int AW      = 20,
  parameter int OIW     = 1
) (
  input  logic [OUT_CNT-1:0][AW-1:0] vals,
  output logic [OIW-1:0]             best
);
  always_comb begin
    logic signed [AW-1:0] top_v;
    top_v = $signed(vals[0]);
    best  = '0;
    for (int k = 1; k < OUT_CNT; k++) begin
      if ($signed(vals[k]) > top_v) begin
        top_v = $signed(vals[k]);
        best  = OIW'(k);
      end
    end
  end
endmodule

// File: rtl/mac_net_seq.sv
module mac_net_seq import nnseq_pkg::*; #(
  parameter int IN_CNT  = 4,
  parameter int HID_CNT = 3,
  parameter int OUT_CNT = 2,
  parameter int DW      = 8,
  parameter int BW      = 16,
  parameter int SHIFT   = 2,
  localparam int MAXN   = imax(IN_CNT, HID_CNT),
  localparam int NW     = IN_CNT * HID_CNT + HID_CNT * OUT_CNT,
  localparam int NB     = HID_CNT + OUT_CNT,
  localparam int AW     = imax(2 * DW + $clog2(MAXN) + 1, BW) + 1,
  localparam int OIW    = imax($clog2(OUT_CNT), 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_valid,
  output logic                        start_ready,
  input  logic [IN_CNT-1:0][DW-1:0]   x_vec,
  input  logic [NW-1:0][DW-1:0]       w_mem,
  input  logic [NB-1:0][BW-1:0]       b_mem,
  output logic [OUT_CNT-1:0][AW-1:0]  scores,
  output logic [OIW-1:0]              best_idx,
  output logic                        done
);
  localparam int CW  = $clog2(MAXN + 2) + 1;
  localparam int NWD = $clog2(imax(HID_CNT, OUT_CNT)) + 1;
  localparam int BIW = imax($clog2(MAXN), 1);
  localparam int WIW = imax($clog2(NW), 1) + 1;
  localparam int BSW = imax($clog2(NB), 1) + 1;

  logic                 busy;
  logic                 lay;
  logic [NWD-1:0]       neu;
  logic [CW-1:0]        inp;
  phase_e               phase;
  logic [DW-1:0]        x_sel;
  logic [DW-1:0]        w_sel;
  logic [BW-1:0]        b_sel;
  logic [WIW-1:0]       w_ix;
  logic [BSW-1:0]       b_ix;
  logic signed [AW-1:0] acc;
  logic [DW-1:0]        act;
  logic [DW-1:0]        bank [2][MAXN];

  nnseq_ctrl #(
    .IN_CNT(IN_CNT), .HID_CNT(HID_CNT), .OUT_CNT(OUT_CNT), .CW(CW), .NWD(NWD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .busy(busy), .lay(lay), .neu(neu), .inp(inp), .phase(phase), .done(done)
  );

  // operand steering: weight rows of the hidden layer come first
  always_comb begin
    if (lay) begin
      w_ix = WIW'(IN_CNT * HID_CNT) + WIW'(neu) * WIW'(HID_CNT) + WIW'(inp);
      b_ix = BSW'(HID_CNT) + BSW'(neu);
    end else begin
      w_ix = WIW'(neu) * WIW'(IN_CNT) + WIW'(inp);
      b_ix = BSW'(neu);
    end
    x_sel = '0;
    w_sel = '0;
    b_sel = '0;
    if (phase == PH_MAC) begin
      x_sel = bank[lay][inp[BIW-1:0]];
      w_sel = w_mem[w_ix];
    end
    if (phase == PH_BIAS) b_sel = b_mem[b_ix];
  end

  nnseq_mac #(.DW(DW), .BW(BW), .AW(AW), .SHIFT(SHIFT)) u_mac (
    .clk(clk), .rst_n(rst_n), .phase(phase), .first(inp == '0),
    .x(x_sel), .w(w_sel), .bias(b_sel), .acc(acc), .act(act)
  );

  // ping-pong banks: read bank = layer parity, results go to the other one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 2; a++)
        for (int i = 0; i < MAXN; i++) bank[a][i] <= '0;
      scores <= '0;
    end else begin
      if (start_valid && start_ready)
        for (int i = 0; i < IN_CNT; i++) bank[0][i] <= x_vec[i];
      if (phase == PH_ACT) begin
        if (lay != 1'(NLAYER - 1)) bank[~lay][neu[BIW-1:0]] <= act;
        else                       scores[neu[OIW-1:0]] <= acc;
      end
    end
  end

  nnseq_argmax #(.OUT_CNT(OUT_CNT), .AW(AW), .OIW(OIW)) u_argmax (
    .vals(scores), .best(best_idx)
  );

  // R8: results hold while idle and no request is taken
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_valid) |=> $stable(scores));

  // R6: raw scores are written only in the last layer's resolve step
  assert_score_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lay) |=> $stable(scores));
endmodule

// File: tb/mac_net_seq_tb.sv
module mac_net_seq_tb;
  localparam int IN = 4, HID = 3, OUT = 2, DW = 8, BW = 16, SHIFT = 2;
  localparam int NW = IN * HID + HID * OUT;
  localparam int NB = HID + OUT;
  localparam int AW = 20;
  localparam int LAT = (IN + 2) * HID + (HID + 2) * OUT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [IN-1:0][DW-1:0]  x_vec = '0;
  logic [NW-1:0][DW-1:0]  w_mem = '0;
  logic [NB-1:0][BW-1:0]  b_mem = '0;
  logic [OUT-1:0][AW-1:0] scores;
  logic [0:0] best_idx;
  logic done;

  always #5 clk = ~clk;

  mac_net_seq #(.IN_CNT(IN), .HID_CNT(HID), .OUT_CNT(OUT), .DW(DW), .BW(BW), .SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .x_vec(x_vec), .w_mem(w_mem), .b_mem(b_mem), .scores(scores),
    .best_idx(best_idx), .done(done)
  );

  int errors = 0, checks = 0;
  longint cyc = 0;
  int wv [NW];
  int bv [NB];
  int xv [IN];
  longint exp_s_q [$];
  int     exp_b_q [$];
  longint t0_q [$];
  longint last_s [OUT];
  int     last_b;
  logic   prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_params();
    for (int i = 0; i < NW; i++) w_mem[i] = wv[i][DW-1:0];
    for (int i = 0; i < NB; i++) b_mem[i] = bv[i][BW-1:0];
  endtask

  // reference model written from R5, R6, R7
  task automatic push_expected();
    longint h [HID];
    longint s, y, bestv;
    int bi;
    for (int j = 0; j < HID; j++) begin
      s = bv[j];
      for (int i = 0; i < IN; i++) s += longint'(wv[j * IN + i]) * xv[i];
      y = s >>> SHIFT;
      if (y < 0) y = 0;
      if (y > 127) y = 127;
      h[j] = y;
    end
    bi = 0;
    bestv = 0;
    for (int k = 0; k < OUT; k++) begin
      s = bv[HID + k];
      for (int j = 0; j < HID; j++) s += longint'(wv[IN * HID + k * HID + j]) * h[j];
      exp_s_q.push_back(s);
      if (k == 0 || s > bestv) begin bestv = s; bi = k; end
    end
    exp_b_q.push_back(bi);
  endtask

  task automatic start_run(input bit disturb);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    for (int i = 0; i < IN; i++) x_vec[i] = xv[i][DW-1:0];
    start_valid = 1'b1;
    push_expected();
    @(posedge clk);
    #1;
    t0_q.push_back(cyc);
    @(negedge clk);
    start_valid = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      for (int n = 0; n < 5; n++) begin
        for (int i = 0; i < IN; i++) x_vec[i] = DW'(100 - 17 * i + n);
        start_valid = 1'b1;
        #1;
        chk(start_ready == 1'b0, "R2", "start_ready while busy", start_ready, 0);
        @(negedge clk);
      end
      start_valid = 1'b0;
    end
  endtask

  task automatic wait_drain();
    while (t0_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        chk(!prev_done, "R4", "done longer than one cycle", 1, 0);
        chk(start_ready == 1'b1, "R4", "start_ready with done", start_ready, 1);
        if (t0_q.size() == 0) begin
          chk(1'b0, "R3", "done without a run", 1, 0);
        end else begin
          longint t0;
          t0 = t0_q.pop_front();
          chk(cyc - t0 == LAT, "R3", "latency", cyc - t0, LAT);
          for (int k = 0; k < OUT; k++) begin
            longint e, a;
            e = exp_s_q.pop_front();
            a = longint'($signed(scores[k]));
            last_s[k] = e;
            chk(a == e, "R5/R6", $sformatf("score[%0d]", k), a, e);
          end
          last_b = exp_b_q.pop_front();
          chk(int'(best_idx) == last_b, "R7", "best_idx", best_idx, last_b);
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) wv[i] = ((i * 7 + 3) % 11) - 5;
    for (int i = 0; i < NB; i++) bv[i] = (i * 13) % 9 - 4;
    apply_params();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(start_ready == 1'b1, "R1", "start_ready after reset", start_ready, 1);
    chk(scores == '0, "R1", "scores after reset", scores, 0);
    chk(best_idx == 1'b0, "R1", "best_idx after reset", best_idx, 0);

    // ordinary mixed data
    xv = '{10, -20, 30, 5};
    start_run(1'b0);
    wait_drain();

    // R5 saturation of hidden values
    for (int i = 0; i < IN * HID; i++) wv[i] = 100;
    for (int i = IN * HID; i < NW; i++) wv[i] = ((i * 5) % 9) - 4;
    for (int i = 0; i < NB; i++) bv[i] = 0;
    apply_params();
    xv = '{127, 127, 127, 127};
    start_run(1'b0);
    wait_drain();

    // R5 negative clamp, R6 negative raw scores, R7 picks index 1
    for (int i = 0; i < HID; i++) bv[i] = -30000;
    bv[HID] = -500;
    bv[HID + 1] = -200;
    apply_params();
    xv = '{3, 4, 5, 6};
    start_run(1'b0);
    wait_drain();

    // R7 tie: identical output rows and biases, lowest index wins
    for (int i = 0; i < IN * HID; i++) wv[i] = ((i * 7 + 3) % 11) - 5;
    for (int j = 0; j < HID; j++) begin
      wv[IN * HID + j] = 9 - 4 * j;
      wv[IN * HID + HID + j] = 9 - 4 * j;
    end
    for (int i = 0; i < HID; i++) bv[i] = 40;
    bv[HID] = 7;
    bv[HID + 1] = 7;
    apply_params();
    xv = '{50, 60, -10, 20};
    start_run(1'b0);
    wait_drain();

    // R2: requests and new inputs during a run are ignored
    for (int i = IN * HID; i < NW; i++) wv[i] = ((i * 3) % 7) - 3;
    bv[HID] = 11;
    bv[HID + 1] = -9;
    apply_params();
    xv = '{-40, 25, 70, -5};
    start_run(1'b1);
    wait_drain();

    // R8: idle hold with input noise and no request
    for (int n = 0; n < 15; n++) begin
      x_vec[0] = DW'(n * 9);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done while idle", done, 0);
    end
    for (int k = 0; k < OUT; k++)
      chk(longint'($signed(scores[k])) == last_s[k], "R8", $sformatf("held score[%0d]", k),
          longint'($signed(scores[k])), last_s[k]);
    chk(int'(best_idx) == last_b, "R8", "held best_idx", best_idx, last_b);

    // R9: back-to-back runs, second accepted in the done cycle
    xv = '{90, -90, 45, 12};
    start_run(1'b0);
    while (!done) @(negedge clk);
    xv = '{-7, 33, 0, 101};
    for (int i = 0; i < IN; i++) x_vec[i] = xv[i][DW-1:0];
    start_valid = 1'b1;
    push_expected();
    @(posedge clk);
    #1;
    t0_q.push_back(cyc);
    @(negedge clk);
    start_valid = 1'b0;
    wait_drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule